// File: doc/BRIEF.md
# Encoder Position Preset and Offset Unit

This block sits between an encoder's position converter and its output stage. Each conversion delivers a singleturn word and a multiturn count on a valid/ready input stream. The block subtracts a stored singleturn offset and a stored multiturn offset from them, then presents the corrected pair on a valid/ready output stream. A single register stage separates the two streams. Back-pressure works as follows: a held output stays stable until it is accepted, and the input is ready whenever the stage is empty or is being emptied in the same cycle.

A preset makes the reported position equal a chosen value at the moment of capture. It starts on a rising edge of the preset pin, after a two-flop synchronizer, or when the preset command code is written over the register bus. The preset sequence does three things:
- It captures the most recently accepted position.
- It takes the preset values from the preset registers when non-volatile memory is flagged present, or uses zero when it is absent.
- It stores offsets equal to the captured position minus the preset, modulo the configured data length.

When non-volatile memory is present, the sequence then asks for a write-back of the register contents and waits for the acknowledge. While the sequence runs, a busy flag is high and the register bus is closed.

Top module: `pos_preset_unit`

## Requirements
- R1: A preset starts on a rising edge of `preset_pin`, seen through a two-flop synchronizer; `busy` rises at most four cycles after the pin rises. Holding the pin high does not start another preset.
- R2: Writing 0x02 to the command address 0x7F starts a preset, and `busy` reads 1 in the cycle after the write edge. Writing any other value there has no effect. The command address always reads 0.
- R3: At the end of a preset, the singleturn offset becomes (last accepted `in_st` − singleturn preset) mod 2^ST_DL, and the multiturn offset becomes (last accepted `in_mt` − multiturn preset) mod 2^MT_DL. Every conversion accepted afterwards outputs `in_st` − singleturn offset and `in_mt` − multiturn offset, each wrapping modulo its width. The offsets change only through a preset or a bus write.
- R4: When `nvm_present` is 0 at capture, both preset values are taken as zero, so the offsets equal the captured position.
- R5: The singleturn preset occupies bytes 0x50 (least significant) to 0x54 of a 40-bit little-endian field. Its MSB is field bit 38, which is bit 6 of byte 0x54, and it spans ST_DL bits downward from there. All other bits of the field ignore writes and read 0.
- R6: The multiturn preset occupies bytes 0x55 to 0x57 and is right-justified, spanning MT_DL bits from bit 0. The singleturn offset occupies bytes 0x30 to 0x34 and is right-justified over ST_DL bits. The multiturn offset occupies bytes 0x35 to 0x37 and is right-justified over MT_DL bits. All four fields are writable, and bits outside each field read 0. An offset written over the bus is applied to later conversions.
- R7: While `busy` is 1, `reg_rdata` reads 0 and register writes are ignored. A preset keeps `busy` high for at least two cycles.
- R8: A trigger from either source that arrives while `busy` is 1 is ignored.
- R9: When `nvm_present` was 1 at capture, `nvm_wb_req` rises after the offsets are stored and stays high until `nvm_wb_ack` is sampled high. `busy` then falls in the next cycle.
- R10: The stream stage works as follows. `in_ready` = !`out_valid` || `out_ready`. A held output keeps its data while `out_ready` is 0. Each accepted input appears on the output in the next cycle.
- R11: After reset, `busy`, `out_valid` and `nvm_wb_req` are 0, `in_ready` is 1, and all preset and offset registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_pin | input | 1 | Asynchronous preset request, rising edge |
| nvm_present | input | 1 | Non-volatile memory fitted |
| nvm_wb_ack | input | 1 | Write-back finished |
| nvm_wb_req | output | 1 | Write-back request |
| busy | output | 1 | Preset sequence running |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| in_valid | input | 1 | Conversion valid |
| in_ready | output | 1 | Conversion accepted |
| in_st | input | ST_DL | Synchronized singleturn word |
| in_mt | input | MT_DL | Multiturn count |
| out_valid | output | 1 | Corrected position valid |
| out_ready | input | 1 | Consumer ready |
| out_st | output | ST_DL | Corrected singleturn word |
| out_mt | output | MT_DL | Corrected multiturn count |

## Verification
The bench uses the default widths: ST_DL = 16 and MT_DL = 12. Both subtractions therefore wrap after a few steps of the test pattern, and the bench checks positions that lie below their offsets. With a 16-bit singleturn word placed MSB-first at field bit 38, the 23 low bits of the singleturn preset field must stay zero, and the 12-bit multiturn field leaves a full byte and a half-byte that must also read zero. Both of these masking cases are exercised by writing all-ones.

// File: rtl/pos_preset_pkg.sv
package pos_preset_pkg;
  localparam int ST_BYTES   = 5;
  localparam int MT_BYTES   = 3;
  localparam int ST_FIELD_W = 39;
  localparam logic [7:0] ADDR_OFS_ST = 8'h30;
  localparam logic [7:0] ADDR_OFS_MT = 8'h35;
  localparam logic [7:0] ADDR_PRE_ST = 8'h50;
  localparam logic [7:0] ADDR_PRE_MT = 8'h55;
  localparam logic [7:0] ADDR_CMD    = 8'h7F;
  localparam logic [7:0] CMD_PRESET  = 8'h02;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CAPTURE,
    SQ_STORE,
    SQ_SAVE
  } seq_state_e;
endpackage

// File: rtl/pp_byte_reg.sv
module pp_byte_reg #(
  parameter int                  NBYTES = 5,
  parameter logic [7:0]          BASE   = 8'h30,
  parameter logic [8*NBYTES-1:0] MASK   = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_allow,
  input  logic [7:0]            addr,
  input  logic                  wr,
  input  logic [7:0]            wdata,
  input  logic                  ld,
  input  logic [8*NBYTES-1:0]   ld_val,
  output logic [8*NBYTES-1:0]   q,
  output logic                  hit,
  output logic [7:0]            rbyte
);
  logic [NBYTES-1:0] sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [7:0] BADDR = BASE + 8'(b);
    logic [7:0] r;
    assign sel[b] = (addr == BADDR);
    assign q[8*b +: 8] = r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r <= '0;
      else if (ld)
        r <= ld_val[8*b +: 8] & MASK[8*b +: 8];
      else if (wr && wr_allow && sel[b])
        r <= wdata & MASK[8*b +: 8];
    end
  end

  assign hit = |sel;

  always_comb begin
    rbyte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (sel[b]) rbyte = q[8*b +: 8];
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && wr_allow) && !ld) |=> $stable(q));
endmodule

// File: rtl/pp_trig_detect.sv
module pp_trig_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic cmd_hit,
  input  logic busy,
  output logic trig
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_rise = sync_q[SYNC_STAGES-1] && !prev_q;
  assign trig     = (pin_rise || cmd_hit) && !busy;
endmodule

// File: rtl/pp_preset_seq.sv
module pp_preset_seq
  import pos_preset_pkg::*;
#(
  parameter int ST_DL = 16,
  parameter int MT_DL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             nvm_present,
  input  logic             nvm_ack,
  input  logic [ST_DL-1:0] last_st,
  input  logic [MT_DL-1:0] last_mt,
  input  logic [ST_DL-1:0] pre_st,
  input  logic [MT_DL-1:0] pre_mt,
  output logic             busy,
  output logic             ld,
  output logic [ST_DL-1:0] ofs_st,
  output logic [MT_DL-1:0] ofs_mt,
  output logic             wb_req
);
  seq_state_e      st_q, st_d;
  logic [ST_DL-1:0] cap_st, cpre_st;
  logic [MT_DL-1:0] cap_mt, cpre_mt;
  logic             nvm_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:    if (trig) st_d = SQ_CAPTURE;
      SQ_CAPTURE: st_d = SQ_STORE;
      SQ_STORE:   st_d = nvm_q ? SQ_SAVE : SQ_IDLE;
      SQ_SAVE:    if (nvm_ack) st_d = SQ_IDLE;
      default:    st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cap_st  <= '0;
      cap_mt  <= '0;
      cpre_st <= '0;
      cpre_mt <= '0;
      nvm_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_CAPTURE) begin
        cap_st  <= last_st;
        cap_mt  <= last_mt;
        cpre_st <= nvm_present ? pre_st : '0;
        cpre_mt <= nvm_present ? pre_mt : '0;
        nvm_q   <= nvm_present;
      end
    end
  end

  assign busy   = (st_q != SQ_IDLE);
  assign ld     = (st_q == SQ_STORE);
  assign wb_req = (st_q == SQ_SAVE);
  assign ofs_st = cap_st - cpre_st;
  assign ofs_mt = cap_mt - cpre_mt;

  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !nvm_ack) |=> wb_req);
  // R7
  busy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

// File: rtl/pp_pos_adjust.sv
module pp_pos_adjust #(
  parameter int ST_DL = 16,
  parameter int MT_DL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ST_DL-1:0] in_st,
  input  logic [MT_DL-1:0] in_mt,
  input  logic [ST_DL-1:0] ofs_st,
  input  logic [MT_DL-1:0] ofs_mt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ST_DL-1:0] out_st,
  output logic [MT_DL-1:0] out_mt,
  output logic [ST_DL-1:0] last_st,
  output logic [MT_DL-1:0] last_mt
);
  logic in_fire;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_st    <= '0;
      out_mt    <= '0;
      last_st   <= '0;
      last_mt   <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_st    <= in_st - ofs_st;
      out_mt    <= in_mt - ofs_mt;
      last_st   <= in_st;
      last_mt   <= in_mt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_st) && $stable(out_mt)));
endmodule

// File: rtl/pos_preset_unit.sv
module pos_preset_unit
  import pos_preset_pkg::*;
#(
  parameter int ST_DL = 16,
  parameter int MT_DL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_pin,
  input  logic             nvm_present,
  input  logic             nvm_wb_ack,
  output logic             nvm_wb_req,
  output logic             busy,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ST_DL-1:0] in_st,
  input  logic [MT_DL-1:0] in_mt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ST_DL-1:0] out_st,
  output logic [MT_DL-1:0] out_mt
);
  localparam int SW = 8 * ST_BYTES;
  localparam int MW = 8 * MT_BYTES;
  localparam logic [SW-1:0] PRE_ST_MASK = ((SW'(1) << ST_DL) - SW'(1)) << (ST_FIELD_W - ST_DL);
  localparam logic [SW-1:0] OFS_ST_MASK = (SW'(1) << ST_DL) - SW'(1);
  localparam logic [MW-1:0] MT_MASK     = (MW'(1) << MT_DL) - MW'(1);

  logic             trig, cmd_hit, ld;
  logic [ST_DL-1:0] last_st, ofs_st_new;
  logic [MT_DL-1:0] last_mt, ofs_mt_new;
  logic [SW-1:0]    pst_q, ost_q;
  logic [MW-1:0]    pmt_q, omt_q;
  logic             pst_hit, pmt_hit, ost_hit, omt_hit;
  logic [7:0]       pst_rb, pmt_rb, ost_rb, omt_rb;
  logic             wr_allow;

  assign wr_allow = !busy;
  assign cmd_hit  = reg_wr && wr_allow && (reg_addr == ADDR_CMD) && (reg_wdata == CMD_PRESET);

  pp_trig_detect #(.SYNC_STAGES(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .pin(preset_pin), .cmd_hit(cmd_hit),
    .busy(busy), .trig(trig)
  );

  pp_byte_reg #(.NBYTES(ST_BYTES), .BASE(ADDR_PRE_ST), .MASK(PRE_ST_MASK)) u_pre_st (
    .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .ld(1'b0), .ld_val('0), .q(pst_q), .hit(pst_hit), .rbyte(pst_rb)
  );

  pp_byte_reg #(.NBYTES(MT_BYTES), .BASE(ADDR_PRE_MT), .MASK(MT_MASK)) u_pre_mt (
    .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .ld(1'b0), .ld_val('0), .q(pmt_q), .hit(pmt_hit), .rbyte(pmt_rb)
  );

  pp_byte_reg #(.NBYTES(ST_BYTES), .BASE(ADDR_OFS_ST), .MASK(OFS_ST_MASK)) u_ofs_st (
    .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .ld(ld), .ld_val(SW'(ofs_st_new)), .q(ost_q), .hit(ost_hit),
    .rbyte(ost_rb)
  );

  pp_byte_reg #(.NBYTES(MT_BYTES), .BASE(ADDR_OFS_MT), .MASK(MT_MASK)) u_ofs_mt (
    .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .ld(ld), .ld_val(MW'(ofs_mt_new)), .q(omt_q), .hit(omt_hit),
    .rbyte(omt_rb)
  );

  pp_preset_seq #(.ST_DL(ST_DL), .MT_DL(MT_DL)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .nvm_present(nvm_present), .nvm_ack(nvm_wb_ack),
    .last_st(last_st), .last_mt(last_mt),
    .pre_st(pst_q[ST_FIELD_W-1 -: ST_DL]), .pre_mt(pmt_q[MT_DL-1:0]),
    .busy(busy), .ld(ld), .ofs_st(ofs_st_new), .ofs_mt(ofs_mt_new), .wb_req(nvm_wb_req)
  );

  pp_pos_adjust #(.ST_DL(ST_DL), .MT_DL(MT_DL)) u_adj (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_st(in_st), .in_mt(in_mt), .ofs_st(ost_q[ST_DL-1:0]), .ofs_mt(omt_q[MT_DL-1:0]),
    .out_valid(out_valid), .out_ready(out_ready), .out_st(out_st), .out_mt(out_mt),
    .last_st(last_st), .last_mt(last_mt)
  );

  always_comb begin
    reg_rdata = '0;
    if (!busy) begin
      if (pst_hit)      reg_rdata = pst_rb;
      else if (pmt_hit) reg_rdata = pmt_rb;
      else if (ost_hit) reg_rdata = ost_rb;
      else if (omt_hit) reg_rdata = omt_rb;
    end
  end

  // R1
  trig_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy);
  // R8
  single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R7
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pst_q) && $stable(pmt_q)));
  // R3
  ofs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ost_q != $past(ost_q)) && !$past(reg_wr)) |-> $past(busy));
endmodule

// File: tb/tb_pos_preset_unit.sv
module tb_pos_preset_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ST_DL = 16;
  localparam int MT_DL = 12;
  localparam longint STM = (64'd1 << ST_DL) - 1;
  localparam longint MTM = (64'd1 << MT_DL) - 1;
  localparam int ST_SHIFT = 39 - ST_DL;

  logic clk = 0, rst_n = 0;
  logic preset_pin = 0, nvm_present = 0, nvm_wb_ack = 0;
  logic nvm_wb_req, busy;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_wr = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [ST_DL-1:0] in_st = 0, out_st;
  logic [MT_DL-1:0] in_mt = 0, out_mt;

  int checks = 0, fails = 0;
  longint m_pst = 0, m_pmt = 0, m_ost = 0, m_omt = 0, last_st = 0, last_mt = 0;
  longint q_st[$], q_mt[$];

  pos_preset_unit #(.ST_DL(ST_DL), .MT_DL(MT_DL)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_field(input logic [7:0] a, input int n, output longint v);
    logic [7:0] d;
    v = 0;
    for (int i = 0; i < n; i++) begin
      rd(a + 8'(i), d);
      v = v | (longint'(d) << (8*i));
    end
  endtask

  task automatic wr_pre_st(input longint val);
    longint f = (val & STM) << ST_SHIFT;
    for (int i = 0; i < 5; i++) wr(8'h50 + 8'(i), 8'((f >> (8*i)) & 255));
    m_pst = f;
  endtask

  task automatic wr_pre_mt(input longint val);
    for (int i = 0; i < 3; i++) wr(8'h55 + 8'(i), 8'((val >> (8*i)) & 255));
    m_pmt = val & MTM;
  endtask

  // one cycle of the reference model of the stream stage
  task automatic step(input bit iv, input longint ist, input longint imt, input bit ordy);
    @(negedge clk);
    chk("R10 out_valid", out_valid, q_st.size() > 0);
    if (q_st.size() > 0) begin
      chk("R3 out_st", out_st, q_st[0]);
      chk("R3 out_mt", out_mt, q_mt[0]);
    end
    in_valid = iv; in_st = ST_DL'(ist); in_mt = MT_DL'(imt); out_ready = ordy;
    #1;
    chk("R10 in_ready", in_ready, (q_st.size() == 0) || ordy);
    if (out_valid && out_ready) begin void'(q_st.pop_front()); void'(q_mt.pop_front()); end
    if (in_valid && in_ready) begin
      q_st.push_back((ist - m_ost) & STM);
      q_mt.push_back((imt - m_omt) & MTM);
      last_st = ist & STM; last_mt = imt & MTM;
    end
  endtask

  task automatic run_stream(input int n, input longint b_st, input longint b_mt);
    for (int i = 0; i < n; i++)
      step(i % 3 != 2, (b_st + i * 64'h1357) & STM, (b_mt + i * 37) & MTM, i % 4 != 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    chk("R7 busy ends", busy, 0);
  endtask

  task automatic check_offsets(string req);
    longint v;
    rd_field(8'h30, 5, v); chk(req, v, m_ost);
    rd_field(8'h35, 3, v); chk(req, v, m_omt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    longint v;
    int seen;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R11 reset state
    @(negedge clk);
    chk("R11 busy", busy, 0); chk("R11 out_valid", out_valid, 0);
    chk("R11 in_ready", in_ready, 1); chk("R11 wb_req", nvm_wb_req, 0);
    rd_field(8'h30, 5, v); chk("R11 ofs_st", v, 0);
    rd_field(8'h50, 5, v); chk("R11 pre_st", v, 0);
    rd_field(8'h55, 3, v); chk("R11 pre_mt", v, 0);

    // R10 stream with zero offsets
    run_stream(20, 100, 5);

    // R5 / R6 masking of preset fields
    for (int i = 0; i < 5; i++) wr(8'h50 + 8'(i), 8'hFF);
    rd_field(8'h50, 5, v); chk("R5 pre_st mask", v, STM << ST_SHIFT);
    for (int i = 0; i < 3; i++) wr(8'h55 + 8'(i), 8'hFF);
    rd_field(8'h55, 3, v); chk("R6 pre_mt mask", v, MTM);
    rd(8'h7F, d); chk("R2 cmd reads 0", d, 0);

    wr_pre_st(64'h1234); wr_pre_mt(64'h0AB);
    rd_field(8'h50, 5, v); chk("R5 pre_st layout", v, m_pst);

    // R2 / R4 command preset without memory
    nvm_present = 0;
    wr(8'h7F, 8'h02);
    chk("R2 busy after cmd", busy, 1);
    rd(8'h54, d); chk("R7 read blocked", d, 0);
    wait_idle();
    chk("R9 no wb_req", nvm_wb_req, 0);
    m_ost = last_st; m_omt = last_mt;
    check_offsets("R4 ofs=pos");
    run_stream(16, 64'h0F00, 64'h200);

    // R2 other command value ignored
    wr(8'h7F, 8'h03);
    seen = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R2 other code no preset", seen, 0);

    // R1 / R8 / R9 pin preset with memory
    nvm_present = 1;
    @(negedge clk); preset_pin = 1;
    seen = 0;
    for (int i = 0; i < 4 && !seen; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R1 busy from pin", seen, 1);
    for (int i = 0; i < 10 && !nvm_wb_req; i++) @(negedge clk);
    chk("R9 wb_req", nvm_wb_req, 1);
    wr(8'h50 + 8'd3, 8'h00);              // blocked write, R7
    wr(8'h7F, 8'h02);                     // trigger while busy, R8
    @(negedge clk); preset_pin = 0;
    repeat (3) @(negedge clk); preset_pin = 1;   // edge while busy, R8
    repeat (4) @(negedge clk);
    chk("R9 wb_req held", nvm_wb_req, 1);
    chk("R9 busy held", busy, 1);
    nvm_wb_ack = 1;
    @(negedge clk); nvm_wb_ack = 0;
    chk("R9 busy after ack", busy, 0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R8 R1 no retrigger", seen, 0);
    rd_field(8'h50, 5, v); chk("R7 write ignored", v, m_pst);
    m_ost = (last_st - (m_pst >> ST_SHIFT)) & STM;
    m_omt = (last_mt - m_pmt) & MTM;
    check_offsets("R3 ofs=pos-preset");
    run_stream(24, 64'h0010, 64'h003);   // low values wrap below offsets

    // R6 direct offset write
    wr(8'h30, 8'h34); wr(8'h31, 8'h12); wr(8'h32, 8'h00); wr(8'h33, 8'h00); wr(8'h34, 8'h00);
    wr(8'h35, 8'hFF); wr(8'h36, 8'hFF); wr(8'h37, 8'h00);
    m_ost = 64'h1234; m_omt = MTM;
    check_offsets("R6 ofs write");
    run_stream(12, 64'hFFF0, 64'hFFE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule